// File: doc/BRIEF.md
# PWM Time-Base Counter with Cascaded Prescaler

This block is the counting core of a PWM engine. A base clock passes through two cascaded prescalers: a power-of-two stage and an even-step stage. Together they produce a single-cycle tick enable. On each tick a 16-bit counter advances according to a 2-bit mode. The modes are count up, count down, up-down (triangle) and frozen. Each tick also yields two strobes, one when the count is zero and one when the count equals the period. Downstream compare and action logic uses these strobes to place output edges.

Software configures the block through a small 16-bit register port with byte offsets. The control word sits at 0x00, the live counter at 0x08 and the period at 0x0A. Writing the control word restarts both prescaler stages, so a new ratio takes effect from a known phase. Writing the counter register loads the count directly.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the control word reads 0x0003 (frozen mode, both ratios 1), the period reads 0, the direction output is 1 (up) and neither event strobe is high.
- R2: The control word is at offset 0x00 with the power-of-two field at bits 12:10, the even-step field at bits 9:7 and the mode at bits 1:0; all other control bits read 0. The counter is at 0x08 and the period at 0x0A. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R3: `tick` is high for one base-clock cycle out of every R cycles, where R = 2^c × (h == 0 ? 1 : 2h), c is the bits 12:10 field and h is the bits 9:7 field. Counting the cycle after a control write as cycle 0, tick is high in the cycles k with (k+1) mod R == 0.
- R4: A control word write restarts both prescaler stages, even when the ratio is unchanged, so the next tick follows R3 counted from that write.
- R5: Mode 0 (up): on each tick the count goes up by 1, and it goes to 0 when it equals the period; direction output is 1.
- R6: Mode 1 (down): on each tick the count goes down by 1, and it reloads the period when it is 0; direction output is 0.
- R7: Mode 2 (up-down): the count rises to the period, then falls to 0, then rises again, reversing on the tick where it meets either end. The direction output shows the current direction, and a control write sets it to up.
- R8: `evt_zero` is high exactly in tick cycles where the count is 0, and `evt_period` exactly in tick cycles where the count equals the period, both only outside frozen mode.
- R9: Mode 3 (frozen) holds the count on every tick and keeps both event strobes low, even when the count is 0 or equals the period.
- R10: A counter write loads the written value at the next edge, takes priority over a tick in the same cycle, and does not disturb the prescaler phase.
- R11: The full 16-bit range is usable: with period 0xFFFF the up count passes 0xFFFE, 0xFFFF, 0. With period 0 the count stays at 0 and both strobes fire on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write byte offset |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 6 | Register read byte offset |
| rd_data | output | 16 | Register read data (combinational) |
| count | output | 16 | Live counter value |
| dir_up | output | 1 | 1 while counting up, 0 while counting down |
| tick | output | 1 | Prescaled count enable |
| evt_zero | output | 1 | Count-equals-zero strobe |
| evt_period | output | 1 | Count-equals-period strobe |

## Verification
The hardest states to reach are those where two register actions meet a tick in the same cycle. One case is a counter load landing on a tick cycle. Another is a control rewrite placed where the old divider phase would have ticked one cycle later. The stimulus reaches both by running a bench-side model of the tick phase for a known number of cycles. It then issues the write in the exact cycle the model marks as a tick, or as the cycle just before one. It carries the phase offset into the following model run to confirm that the load won over the tick, or that the restart moved the next tick.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  localparam int TB_DW   = 16;
  localparam int TB_AW   = 6;
  localparam int TB_PSW  = 3;
  localparam int MODE_LSB = 0;
  localparam int HS_LSB   = 7;
  localparam int CD_LSB   = HS_LSB + TB_PSW;

  localparam logic [TB_AW-1:0] OFF_CTRL  = 6'h00;
  localparam logic [TB_AW-1:0] OFF_COUNT = 6'h08;
  localparam logic [TB_AW-1:0] OFF_PRD   = 6'h0A;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_HOLD = 2'd3
  } cnt_mode_e;

  function automatic int unsigned pow2_ratio(input logic [TB_PSW-1:0] n);
    return 32'd1 << n;
  endfunction

  function automatic int unsigned even_ratio(input logic [TB_PSW-1:0] n);
    return (n == '0) ? 32'd1 : 32'd2 * int'(n);
  endfunction

  function automatic int unsigned tick_ratio(input logic [TB_PSW-1:0] cd,
                                             input logic [TB_PSW-1:0] hs);
    return pow2_ratio(cd) * even_ratio(hs);
  endfunction
endpackage

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
  import pwm_tb_pkg::*;
#(
  parameter int DW   = TB_DW,
  parameter int AW   = TB_AW,
  parameter int PS_W = TB_PSW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   count_in,
  output logic [DW-1:0]   rd_data,
  output logic [PS_W-1:0] cdiv,
  output logic [PS_W-1:0] hsdiv,
  output cnt_mode_e       mode,
  output logic [DW-1:0]   prd,
  output logic            ctrl_wr,
  output logic            cnt_wr
);
  localparam int CD_L = HS_LSB + PS_W;

  logic prd_wr;
  logic [DW-1:0] ctrl_view;

  assign ctrl_wr = wr_en && (wr_addr == AW'(OFF_CTRL));
  assign cnt_wr  = wr_en && (wr_addr == AW'(OFF_COUNT));
  assign prd_wr  = wr_en && (wr_addr == AW'(OFF_PRD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cdiv  <= '0;
      hsdiv <= '0;
      mode  <= MODE_HOLD;
    end else if (ctrl_wr) begin
      cdiv  <= wr_data[CD_L +: PS_W];
      hsdiv <= wr_data[HS_LSB +: PS_W];
      mode  <= cnt_mode_e'(wr_data[MODE_LSB +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prd <= '0;
    else if (prd_wr) prd <= wr_data;
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CD_L +: PS_W]   = cdiv;
    ctrl_view[HS_LSB +: PS_W] = hsdiv;
    ctrl_view[MODE_LSB +: 2]  = mode;
  end

  always_comb begin
    unique case (rd_addr)
      AW'(OFF_CTRL):  rd_data = ctrl_view;
      AW'(OFF_COUNT): rd_data = count_in;
      AW'(OFF_PRD):   rd_data = prd;
      default:        rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [PS_W-1:0] cdiv,
  input  logic [PS_W-1:0] hsdiv,
  output logic            tick
);
  localparam int C1W = (1 << PS_W) - 1;
  localparam int C2W = PS_W + 1;

  logic [C1W:0]   one_hot;
  logic [C1W-1:0] lim1, c1_q;
  logic [C2W-1:0] lim2, c2_q;
  logic           en1;

  assign one_hot = (C1W+1)'(1) << cdiv;
  assign lim1    = C1W'(one_hot - (C1W+1)'(1));
  assign lim2    = (hsdiv == '0) ? '0 : C2W'({hsdiv, 1'b0} - C2W'(1));
  assign en1     = (c1_q == lim1);
  assign tick    = en1 && (c2_q == lim2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       c1_q <= '0;
    else if (restart) c1_q <= '0;
    else if (en1)     c1_q <= '0;
    else              c1_q <= c1_q + C1W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       c2_q <= '0;
    else if (restart) c2_q <= '0;
    else if (en1)     c2_q <= (c2_q == lim2) ? '0 : c2_q + C2W'(1);
  end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int DW = TB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  cnt_mode_e     mode,
  input  logic [DW-1:0] prd,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          dir_reset,
  output logic [DW-1:0] count,
  output logic          dir_up,
  output logic          evt_zero,
  output logic          evt_period
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  logic          active, at_zero, at_prd;

  assign at_zero = (cnt_q == '0);
  assign at_prd  = (cnt_q == prd);
  assign active  = tick && (mode != MODE_HOLD);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (load) begin
      cnt_d = load_val;
    end else if (active) begin
      unique case (mode)
        MODE_UP:   cnt_d = at_prd ? '0 : cnt_q + DW'(1);
        MODE_DOWN: cnt_d = at_zero ? prd : cnt_q - DW'(1);
        MODE_UPDN: begin
          if (at_prd && at_zero) begin
            cnt_d = '0;
          end else if (dir_q) begin
            if (at_prd) begin
              dir_d = 1'b0;
              cnt_d = cnt_q - DW'(1);
            end else begin
              cnt_d = cnt_q + DW'(1);
            end
          end else begin
            if (at_zero) begin
              dir_d = 1'b1;
              cnt_d = cnt_q + DW'(1);
            end else begin
              cnt_d = cnt_q - DW'(1);
            end
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
    if (dir_reset) dir_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign count      = cnt_q;
  assign evt_zero   = active && at_zero;
  assign evt_period = active && at_prd;

  always_comb begin
    unique case (mode)
      MODE_UP:   dir_up = 1'b1;
      MODE_DOWN: dir_up = 1'b0;
      default:   dir_up = dir_q;
    endcase
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int DW   = TB_DW,
  parameter int AW   = TB_AW,
  parameter int PS_W = TB_PSW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] count,
  output logic          dir_up,
  output logic          tick,
  output logic          evt_zero,
  output logic          evt_period
);
  logic [PS_W-1:0] cdiv_w, hs_w;
  cnt_mode_e       mode_w;
  logic [DW-1:0]   prd_w;
  logic            ctrl_wr_w, cnt_wr_w;

  pwm_tb_regs #(.DW(DW), .AW(AW), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .count_in(count),
    .rd_data(rd_data), .cdiv(cdiv_w), .hsdiv(hs_w), .mode(mode_w),
    .prd(prd_w), .ctrl_wr(ctrl_wr_w), .cnt_wr(cnt_wr_w)
  );

  pwm_tb_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr_w),
    .cdiv(cdiv_w), .hsdiv(hs_w), .tick(tick)
  );

  pwm_tb_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_w), .prd(prd_w),
    .load(cnt_wr_w), .load_val(wr_data), .dir_reset(ctrl_wr_w),
    .count(count), .dir_up(dir_up), .evt_zero(evt_zero),
    .evt_period(evt_period)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_tb_pkg::*;
#(
  parameter int DW   = TB_DW,
  parameter int PS_W = TB_PSW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            evt_zero,
  input logic            evt_period,
  input logic [DW-1:0]   count,
  input logic [DW-1:0]   prd,
  input cnt_mode_e       mode,
  input logic            cnt_wr,
  input logic            ctrl_wr,
  input logic [DW-1:0]   wr_data,
  input logic [PS_W-1:0] cdiv,
  input logic [PS_W-1:0] hsdiv
);
  AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_zero || evt_period) |-> tick); // R8

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |-> (!evt_zero && !evt_period)); // R9

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && !cnt_wr) |=> (count == $past(count))); // R9

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_UP && count == prd && !cnt_wr) |=> (count == '0)); // R5

  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_DOWN && count == '0 && !cnt_wr) |=> (count == $past(prd))); // R6

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(wr_data))); // R10

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr && tick_ratio(cdiv, hsdiv) > 1) |=> !tick); // R3
endmodule

bind pwm_timebase pwm_timebase_chk #(.DW(DW), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .evt_zero(evt_zero),
  .evt_period(evt_period), .count(count), .prd(prd_w), .mode(mode_w),
  .cnt_wr(cnt_wr_w), .ctrl_wr(ctrl_wr_w), .wr_data(wr_data),
  .cdiv(cdiv_w), .hsdiv(hs_w)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data, count;
  logic        dir_up, tick, evt_zero, evt_period;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_timebase u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .dir_up(dir_up), .tick(tick),
    .evt_zero(evt_zero), .evt_period(evt_period)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t",
               req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk(input int cd, input int hs, input int md);
    return 16'((cd << 10) | (hs << 7) | md);
  endfunction

  task automatic reg_write(input logic [5:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic setup(input logic [15:0] prd, input logic [15:0] start,
                       input logic [15:0] ctrl);
    reg_write(6'h00, 16'h0003);
    reg_write(6'h08, start);
    reg_write(6'h0A, prd);
    reg_write(6'h00, ctrl);
  endtask

  // Bench model of tick phase and counting, cycle k counted from phase.
  task automatic run_model(input int md, input int ratio, input int phase,
                           input logic [15:0] prd, input logic [15:0] start,
                           input int n, input string req,
                           output logic [15:0] fin);
    logic [15:0] ec;
    logic ed, et;
    ec = start;
    ed = 1'b1;
    for (int k = 0; k < n; k++) begin
      et = (((k + phase + 1) % ratio) == 0);
      check("R3", "tick", int'(tick), int'(et));
      check(req, "count", int'(count), int'(ec));
      check("R8", "evt_zero", int'(evt_zero), int'(et && md != 3 && ec == 0));
      check("R8", "evt_period", int'(evt_period), int'(et && md != 3 && ec == prd));
      if (md == 0) check(req, "dir", int'(dir_up), 1);
      if (md == 1) check(req, "dir", int'(dir_up), 0);
      if (md == 2) check(req, "dir", int'(dir_up), int'(ed));
      if (et && md != 3) begin
        case (md)
          0: ec = (ec == prd) ? 16'd0 : ec + 16'd1;
          1: ec = (ec == 0) ? prd : ec - 16'd1;
          default: begin
            if (prd == 0) ec = 16'd0;
            else if (ed) begin
              if (ec == prd) begin ed = 1'b0; ec = ec - 16'd1; end
              else ec = ec + 16'd1;
            end else begin
              if (ec == 0) begin ed = 1'b1; ec = ec + 16'd1; end
              else ec = ec - 16'd1;
            end
          end
        endcase
      end
      @(negedge clk);
    end
    fin = ec;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1", "count", int'(count), 0);
    check("R1", "dir_up", int'(dir_up), 1);
    check("R1", "evt_zero", int'(evt_zero), 0);
    check("R1", "evt_period", int'(evt_period), 0);
    reg_read(6'h00, d); check("R1", "ctrl", int'(d), 16'h0003);
    reg_read(6'h0A, d); check("R1", "period", int'(d), 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    reg_write(6'h0A, 16'h1234);
    reg_read(6'h0A, d); check("R2", "period readback", int'(d), 16'h1234);
    reg_write(6'h08, 16'h00AB);
    check("R2", "count port", int'(count), 16'h00AB);
    reg_read(6'h08, d); check("R2", "count readback", int'(d), 16'h00AB);
    reg_write(6'h00, 16'hFFFF);
    reg_read(6'h00, d); check("R2", "ctrl readback", int'(d), 16'h1F83);
    reg_write(6'h02, 16'h5555);
    reg_read(6'h00, d); check("R2", "ctrl after stray write", int'(d), 16'h1F83);
    reg_read(6'h0A, d); check("R2", "period after stray write", int'(d), 16'h1234);
    reg_read(6'h08, d); check("R2", "count after stray write", int'(d), 16'h00AB);
    reg_read(6'h02, d); check("R2", "unmapped read", int'(d), 0);
  endtask

  task automatic t_up();
    logic [15:0] f;
    setup(16'd4, 16'd0, mk(0, 0, 0));
    run_model(0, 1, 0, 16'd4, 16'd0, 14, "R5", f);
    setup(16'hFFFF, 16'hFFFE, mk(0, 0, 0));
    run_model(0, 1, 0, 16'hFFFF, 16'hFFFE, 4, "R11", f);
    setup(16'd0, 16'd0, mk(0, 0, 0));
    run_model(0, 1, 0, 16'd0, 16'd0, 4, "R11", f);
  endtask

  task automatic t_down();
    logic [15:0] f;
    setup(16'd3, 16'd2, mk(1, 0, 1));
    run_model(1, 2, 0, 16'd3, 16'd2, 20, "R6", f);
  endtask

  task automatic t_updown();
    logic [15:0] f;
    setup(16'd3, 16'd0, mk(1, 2, 2));
    run_model(2, 8, 0, 16'd3, 16'd0, 64, "R7", f);
    setup(16'd2, 16'd2, mk(0, 0, 2));
    run_model(2, 1, 0, 16'd2, 16'd2, 9, "R7", f);
  endtask

  task automatic t_prescale();
    logic [15:0] f;
    setup(16'd2, 16'd0, mk(2, 3, 0));
    run_model(0, 24, 0, 16'd2, 16'd0, 100, "R3", f);
    setup(16'd1, 16'd0, mk(7, 7, 0));
    run_model(0, 1792, 0, 16'd1, 16'd0, 3600, "R3", f);
  endtask

  task automatic t_restart();
    logic [15:0] f;
    setup(16'd5, 16'd0, mk(1, 1, 0));
    run_model(0, 4, 0, 16'd5, 16'd0, 6, "R4", f);
    // old phase would tick one cycle after this write
    reg_write(6'h00, mk(1, 1, 0));
    run_model(0, 4, 0, 16'd5, f, 12, "R4", f);
  endtask

  task automatic t_freeze();
    logic [15:0] f, c0;
    setup(16'd4, 16'd1, mk(0, 0, 2));
    run_model(2, 1, 0, 16'd4, 16'd1, 5, "R7", f);
    reg_write(6'h00, mk(0, 0, 3));
    c0 = count;
    run_model(3, 1, 0, 16'd4, c0, 10, "R9", f);
    setup(16'd0, 16'd0, mk(0, 0, 3));
    run_model(3, 1, 0, 16'd0, 16'd0, 6, "R9", f);
  endtask

  task automatic t_load();
    logic [15:0] f;
    setup(16'd9, 16'd0, mk(1, 0, 0));
    run_model(0, 2, 0, 16'd9, 16'd0, 3, "R10", f);
    // this cycle is a tick cycle: load must win
    check("R10", "tick before load", int'(tick), 1);
    reg_write(6'h08, 16'd7);
    run_model(0, 2, 4, 16'd9, 16'd7, 10, "R10", f);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_up();
    t_down();
    t_updown();
    t_prescale();
    t_restart();
    t_freeze();
    t_load();
    finish_run();
  end
endmodule